// File: doc/BRIEF.md
# I2C Register-Access Slave

This block attaches a parallel 8-bit device port to a two-wire I2C bus as a slave. Both bus lines are resynchronised to the system clock and pass through a spike filter whose length is set at run time. START and STOP conditions are recovered from the filtered lines, and the first byte after a START is compared with a 7-bit address taken from an input port. Once that address matches, the block acknowledges and then either takes bytes from the master or sends bytes to it.

A mode input picks one of two ways to move data. In burst mode every written byte goes straight to the device, and every byte read is fetched from the device on demand. In register mode the first written byte is an 8-bit register index, and exactly one data byte is written to or read from that index. A register read is a short write that carries only the index, followed by a repeated START with the read bit set. The device can hold the master off with a wait input, which makes the slave pull SCL low. Each bus line is modelled as a sampled input plus an open-drain pull-down enable.

Top module: `i2c_reg_slave`

## Requirements
- R1: After the asynchronous active-low reset, addr_hit, rw, rd_strobe, wr_strobe, scl_oe and sda_oe are 0, and reg_addr and wr_data are 0x00.
- R2: The first byte after a START is taken MSB first. Its upper seven bits are compared with dev_addr, and bit 0 is the direction: 0 means write, 1 means read. On a match the slave pulls SDA low in the ninth clock, raises addr_hit and copies the direction bit to rw. On a mismatch it does not acknowledge, and it ignores the bus until the next START.
- R3: In burst mode (burst_mode=1) every byte written by the master is acknowledged and placed on wr_data. wr_strobe is high for exactly one system clock per byte.
- R4: In a read transfer, the byte on rd_data is captured at the clock edge that raises rd_strobe for one clock. That byte is shifted out MSB first, and the device advances to its next byte after the strobe. In burst mode a master ACK fetches another byte. A master NACK releases SDA and ends fetching.
- R5: In register mode (burst_mode=0) the first byte after the write address goes to reg_addr and raises no strobe. The second byte goes to wr_data with one wr_strobe. Any later byte is not acknowledged and raises no strobe.
- R6: In register mode reg_addr keeps its value across a repeated START, and a read raises rd_strobe exactly once. A byte the master asks for after that first one reads as 0xFF and raises no strobe.
- R7: A START (SDA falls while SCL is high) restarts address reception from any state. A STOP (SDA rises while SCL is high) returns the slave to idle and clears addr_hit.
- R8: While addr_hit=1 and wait_req=1, the slave pulls SCL low, starting only once the filtered SCL is already low. It lets go after wait_req drops. It never pulls SCL while not addressed.
- R9: With glitch_len=g, a line level must persist for g+1 consecutive system clocks before the filtered line follows it. An SDA pulse of at most g clocks during SCL high therefore does not act as a STOP.
- R10: sda_oe changes only in the clock after a filtered SCL falling edge, or when a START or STOP releases the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glitch_len | input | 3 | Spike filter length; a level must persist glitch_len+1 clocks |
| dev_addr | input | 7 | Slave address to answer |
| burst_mode | input | 1 | 1 = burst streaming, 0 = single-byte register access |
| rd_data | input | 8 | Byte offered by the device for reads |
| wait_req | input | 1 | Device asks the slave to stretch SCL |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| addr_hit | output | 1 | Address matched in the current transfer |
| rw | output | 1 | Direction of the current transfer, 1 = read |
| rd_strobe | output | 1 | One-clock pulse: rd_data captured, advance |
| wr_strobe | output | 1 | One-clock pulse: wr_data holds a new byte |
| reg_addr | output | 8 | Register index received in register mode |
| wr_data | output | 8 | Last byte written by the master |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Spike filtering and STOP detection meet when SDA rises during the high phase of a data bit while the slave is addressed. The shift register has already taken that bit at the rising edge, and the edge must count as a STOP only if the filter lets it through. The bench provokes this by sweeping the width of such an SDA pulse from one clock up to one clock past the filter length, for several filter settings. At each width it checks addr_hit in the middle of the high phase: it must stay 1 for widths up to glitch_len and drop to 0 for longer pulses.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACKOUT,
    ST_TX,
    ST_ACKIN,
    ST_PARK
  } xfer_st_e;

endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] glitch_len,
  input  logic             raw_i,
  output logic             filt_o
);

  logic [1:0]       sync_q;
  logic [LEN_W-1:0] run_q;
  logic             differ;

  assign differ = sync_q[1] ^ filt_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      filt_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (!differ) begin
        run_q <= '0;
      end else if (run_q == glitch_len) begin
        filt_o <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R9: with a filter longer than one clock, the filtered line only moves
  // after the synchronised level held for two consecutive clocks
  p_filt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_o != $past(filt_o)) && ($past(glitch_len) != '0))
      |-> ($past(sync_q[1]) == $past(sync_q[1], 2)));

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] dev_addr,
  input  logic          burst_mode,
  input  logic [DW-1:0] rd_data,
  input  logic          wait_req,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_c,
  input  logic          stop_c,
  output logic          addr_hit,
  output logic          rw,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic [DW-1:0] reg_addr,
  output logic [DW-1:0] wr_data,
  output logic          scl_oe,
  output logic          sda_oe
);

  localparam int CW = $clog2(DW + 1);

  function automatic logic addr_match(input logic [DW-1:0] b, input logic [DW-2:0] a);
    return b[DW-1:1] == a;
  endfunction

  function automatic logic may_fetch(input logic burst, input logic done);
    return burst || !done;
  endfunction

  xfer_st_e      st;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] sr, tx, rx_byte;
  logic          ack_pend, need_reg, one_done, m_nack;
  logic          byte_in, byte_out_end;

  assign rx_byte      = {sr[DW-2:0], sda_f};
  assign byte_in      = scl_rise && (bcnt == CW'(DW - 1));
  assign byte_out_end = scl_fall && (bcnt == CW'(DW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bcnt      <= '0;
      sr        <= '0;
      tx        <= '0;
      ack_pend  <= 1'b0;
      need_reg  <= 1'b0;
      one_done  <= 1'b0;
      m_nack    <= 1'b0;
      addr_hit  <= 1'b0;
      rw        <= 1'b0;
      rd_strobe <= 1'b0;
      wr_strobe <= 1'b0;
      reg_addr  <= '0;
      wr_data   <= '0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      rd_strobe <= 1'b0;
      wr_strobe <= 1'b0;
      scl_oe    <= addr_hit && wait_req && !scl_f;
      if (start_c) begin
        st       <= ST_ADDR;
        bcnt     <= '0;
        sda_oe   <= 1'b0;
        addr_hit <= 1'b0;
      end else if (stop_c) begin
        st       <= ST_IDLE;
        sda_oe   <= 1'b0;
        addr_hit <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              sr   <= rx_byte;
              bcnt <= bcnt + 1'b1;
            end
            if (byte_in && st == ST_ADDR) begin
              if (addr_match(rx_byte, dev_addr)) begin
                addr_hit <= 1'b1;
                rw       <= rx_byte[0];
                ack_pend <= 1'b1;
                need_reg <= !burst_mode && !rx_byte[0];
                one_done <= 1'b0;
              end else begin
                st <= ST_PARK;
              end
            end else if (byte_in) begin
              if (burst_mode) begin
                wr_data   <= rx_byte;
                wr_strobe <= 1'b1;
                ack_pend  <= 1'b1;
              end else if (need_reg) begin
                reg_addr <= rx_byte;
                need_reg <= 1'b0;
                ack_pend <= 1'b1;
              end else if (!one_done) begin
                wr_data   <= rx_byte;
                wr_strobe <= 1'b1;
                one_done  <= 1'b1;
                ack_pend  <= 1'b1;
              end else begin
                ack_pend <= 1'b0;
              end
            end
            if (byte_out_end) begin
              st     <= ST_ACKOUT;
              sda_oe <= ack_pend;
              bcnt   <= '0;
            end
          end
          ST_ACKOUT: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (!ack_pend) begin
                st <= ST_PARK;
              end else if (rw) begin
                st <= ST_TX;
                if (may_fetch(burst_mode, one_done)) begin
                  tx        <= rd_data;
                  rd_strobe <= 1'b1;
                  one_done  <= 1'b1;
                  sda_oe    <= !rd_data[DW-1];
                end else begin
                  tx <= '1;
                end
              end else begin
                st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
            end else if (byte_out_end) begin
              sda_oe <= 1'b0;
              st     <= ST_ACKIN;
            end else if (scl_fall) begin
              tx     <= tx << 1;
              sda_oe <= !tx[DW-2];
            end
          end
          ST_ACKIN: begin
            if (scl_rise) begin
              m_nack <= sda_f;
            end else if (scl_fall) begin
              bcnt <= '0;
              if (m_nack) begin
                st <= ST_PARK;
              end else begin
                st <= ST_TX;
                if (may_fetch(burst_mode, one_done)) begin
                  tx        <= rd_data;
                  rd_strobe <= 1'b1;
                  one_done  <= 1'b1;
                  sda_oe    <= !rd_data[DW-1];
                end else begin
                  tx <= '1;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: a byte delivery strobe lasts exactly one clock
  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  // R4: a fetch strobe lasts exactly one clock
  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);

  // R5: a write delivery and a read fetch never coincide
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe && rd_strobe));

  // R10: SDA drive moves only after a filtered SCL fall or a bus condition
  p_sda_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_c) || $past(stop_c)));

  // R8: stretching begins only on an SCL line that is already low
  p_stretch_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !$past(scl_f));

  // R8: stretching needs an addressed slave and a pending wait
  p_stretch_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> $past(wait_req && addr_hit));

  // R7: a STOP clears the address hit
  p_stop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !addr_hit);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] glitch_len,
  input  logic [DW-2:0]    dev_addr,
  input  logic             burst_mode,
  input  logic [DW-1:0]    rd_data,
  input  logic             wait_req,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             addr_hit,
  output logic             rw,
  output logic             rd_strobe,
  output logic             wr_strobe,
  output logic [DW-1:0]    reg_addr,
  output logic [DW-1:0]    wr_data,
  output logic             scl_oe,
  output logic             sda_oe
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_filt;
  logic scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;

  assign line_raw = {sda_i, scl_i};

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
    i2cs_glitch_filter #(.LEN_W(LEN_W)) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .glitch_len (glitch_len),
      .raw_i      (line_raw[gi]),
      .filt_o     (line_filt[gi])
    );
  end

  assign scl_f = line_filt[0];
  assign sda_f = line_filt[1];

  i2cs_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  i2cs_engine #(.DW(DW)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_addr   (dev_addr),
    .burst_mode (burst_mode),
    .rd_data    (rd_data),
    .wait_req   (wait_req),
    .scl_f      (scl_f),
    .sda_f      (sda_f),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_c    (start_c),
    .stop_c     (stop_c),
    .addr_hit   (addr_hit),
    .rw         (rw),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .reg_addr   (reg_addr),
    .wr_data    (wr_data),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe)
  );

endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;

  localparam int H = 40;
  localparam logic [6:0] DEV = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] glitch_len = 3'd2;
  logic burst_mode = 1'b1;
  logic wait_req = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [7:0] rd_cnt = 8'd0;
  logic [7:0] rd_data;
  logic scl_bus, sda_bus;
  logic addr_hit, rw, rd_strobe, wr_strobe, scl_oe, sda_oe;
  logic [7:0] reg_addr, wr_data;

  int vecs = 0;
  int fails = 0;
  int wr_cnt = 0;
  int stretch_max = 0;
  int cycles = 0;
  logic [7:0] wr_log [16];

  always #5 clk = ~clk;

  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = 8'hA0 + rd_cnt;

  i2c_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .glitch_len(glitch_len), .dev_addr(DEV),
    .burst_mode(burst_mode), .rd_data(rd_data), .wait_req(wait_req),
    .scl_i(scl_bus), .sda_i(sda_bus), .addr_hit(addr_hit), .rw(rw),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .reg_addr(reg_addr),
    .wr_data(wr_data), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  // device model: log deliveries, advance the read source after each fetch
  initial forever begin
    @(negedge clk);
    cycles++;
    if (wr_strobe) begin
      wr_log[wr_cnt % 16] = wr_data;
      wr_cnt++;
    end
    if (rd_strobe) rd_cnt = rd_cnt + 8'd1;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      report();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    int st;
    sda_m = b;
    tick(H);
    scl_m = 1'b1;
    st = 0;
    while (!scl_bus) begin
      tick(1);
      st++;
    end
    if (st > stretch_max) stretch_max = st;
    tick(H / 2);
    s = sda_bus;
    tick(H / 2);
    scl_m = 1'b0;
    tick(H / 4);
  endtask

  task automatic bus_start;
    scl_m = 1'b0; tick(H);
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1;
    while (!scl_bus) tick(1);
    tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H / 4);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1;
    while (!scl_bus) tick(1);
    tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      b = {b[6:0], s};
    end
    bus_bit(~give_ack, s);
  endtask

  initial begin
    logic ack;
    logic [7:0] got;
    logic [7:0] rd0;
    int w0;

    tick(3);
    // R1: reset state
    check("R1 addr_hit", addr_hit, 0);
    check("R1 strobes", {rd_strobe, wr_strobe, rw}, 0);
    check("R1 drives", {scl_oe, sda_oe}, 0);
    check("R1 regs", {reg_addr, wr_data}, 0);
    rst_n = 1'b1;
    tick(5);

    // R2: the own address and every one-bit neighbour
    for (int k = 0; k < 8; k++) begin
      logic [6:0] a;
      a = (k == 0) ? DEV : (DEV ^ 7'(1 << (k - 1)));
      wait_req = (k != 0);
      bus_start();
      put_byte({a, 1'b0}, ack);
      check("R2 ack", ack, k == 0);
      check("R2 addr_hit", addr_hit, k == 0);
      tick(20);
      check("R8 no stretch when unaddressed", scl_oe, 0);
      bus_stop();
      wait_req = 1'b0;
      check("R7 stop clears hit", addr_hit, 0);
    end

    // R3: burst write
    burst_mode = 1'b1;
    w0 = wr_cnt;
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    check("R2 rw write", rw, 0);
    for (int k = 0; k < 3; k++) begin
      put_byte(8'h13 + 8'(k * 8'h59), ack);
      check("R3 data ack", ack, 1);
      check("R3 wr_data", wr_log[(w0 + k) % 16], 8'h13 + 8'(k * 8'h59));
    end
    bus_stop();
    check("R3 strobe count", wr_cnt - w0, 3);
    check("R3 reg_addr untouched", reg_addr, 0);

    // R4: burst read
    rd0 = rd_cnt;
    bus_start();
    put_byte({DEV, 1'b1}, ack);
    check("R2 read ack", ack, 1);
    check("R2 rw read", rw, 1);
    for (int k = 0; k < 4; k++) begin
      get_byte(k < 3, got);
      check("R4 read byte", got, 8'hA0 + rd0 + 8'(k));
    end
    check("R4 nack releases sda", sda_oe, 0);
    check("R4 fetch count", rd_cnt - rd0, 4);
    bus_stop();

    // R5: register-mode write
    burst_mode = 1'b0;
    w0 = wr_cnt;
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    put_byte(8'h3C, ack);
    check("R5 index ack", ack, 1);
    check("R5 reg_addr", reg_addr, 8'h3C);
    check("R5 no strobe on index", wr_cnt - w0, 0);
    put_byte(8'h77, ack);
    check("R5 data ack", ack, 1);
    put_byte(8'h11, ack);
    check("R5 extra byte nacked", ack, 0);
    bus_stop();
    check("R5 one strobe", wr_cnt - w0, 1);
    check("R5 wr_data", wr_data, 8'h77);

    // R6: register-mode read through a repeated START
    rd0 = rd_cnt;
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    put_byte(8'h42, ack);
    bus_start();
    put_byte({DEV, 1'b1}, ack);
    check("R7 repeated start address ack", ack, 1);
    check("R6 reg_addr held", reg_addr, 8'h42);
    get_byte(1'b1, got);
    check("R6 first byte", got, 8'hA0 + rd0);
    get_byte(1'b0, got);
    check("R6 extra byte", got, 8'hFF);
    check("R6 single fetch", rd_cnt - rd0, 1);
    bus_stop();

    // R8: clock stretching
    burst_mode = 1'b1;
    w0 = wr_cnt;
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    wait_req = 1'b1;
    stretch_max = 0;
    fork
      put_byte(8'h9E, ack);
      begin
        tick(100);
        check("R8 scl_oe held", scl_oe, 1);
        check("R8 bus held low", scl_bus, 0);
        tick(200);
        wait_req = 1'b0;
      end
    join
    check("R8 stretched", stretch_max >= 200, 1);
    check("R8 byte after stretch", wr_log[w0 % 16], 8'h9E);
    tick(10);
    check("R8 released", scl_oe, 0);
    bus_stop();

    // R9: SDA pulse width against filter length, during an addressed bit
    for (int g = 0; g < 4; g++) begin
      glitch_len = 3'(g);
      for (int w = 1; w <= g + 2; w++) begin
        bus_start();
        put_byte({DEV, 1'b0}, ack);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H / 2);
        sda_m = 1'b1; tick(w);
        sda_m = 1'b0; tick(H / 2);
        check("R9 pulse vs filter", addr_hit, (w <= g) ? 1 : 0);
        scl_m = 1'b0; tick(H);
        bus_stop();
      end
    end
    glitch_len = 3'd2;

    report();
  end

endmodule